// File: doc/BRIEF.md
# Queued SPI Master Transfer Engine

This block is an SPI master that plays out a short queue of byte transfers prepared in advance by a host. Each queue slot holds a byte to send, the byte received in return, a continue flag and a chip-select choice. The host fills the slots it needs and supplies a first and a last slot index. A one-cycle `go` pulse then starts a run. The engine shifts the slots in order, stores each received byte back into its slot, drops `busy` when the run is over and raises the sticky `done` flag one cycle later.

Chip select is held low from one slot to the next when the slot's continue flag is set. If the flag is clear, chip select goes high for one half bit period before the next slot starts. A frame longer than the queue is sent as several runs. To do this the host holds `lock` high and sets `cont_after` when it starts each run. The engine then keeps chip select low when the run ends. Dropping `lock` while the engine is idle closes the frame. The serial clock idles high. Data changes on the falling edge and is sampled on the rising edge, with 8 bits per slot sent most significant bit first. Each half period of the serial clock lasts `half_div` system cycles, which is the system clock divided by twice the wanted bit rate.

Top module: `spiq_engine`

## Requirements
- R1: After reset, `busy` and `done` are 0, `sck` is 1 and every `cs_n` line is 1.
- R2: A `go` pulse while idle runs slots `first_ptr` through `last_ptr` inclusive. The index wraps from 15 to 0. In the cycle after `go`, `sck` goes to 0 and `mosi` shows bit 7 of the first slot. Each bit is one low half period followed by one high half period, MSB first, and `mosi` changes only while `sck` falls.
- R3: The bit present on `miso` at each rising-edge sample is shifted in MSB first. After the eighth bit the byte is stored in that slot's receive byte, which is readable on `rd_rx` at `rd_idx`.
- R4: A slot whose continue flag is 1 passes straight to the next slot with chip select held low. With the flag at 0, all `cs_n` go high for one half period (with `sck` high) before the next slot.
- R5: `busy` falls in the cycle after the final high half period. `done` rises one cycle after that and stays at 1 until a `done_clr` pulse clears it.
- R6: If `lock` and the `cont_after` value captured at `go` are both 1 when a run ends, the last chip select stays low after the run. Once `lock` is 0 while the engine is idle, all `cs_n` go high in the next cycle.
- R7: Slot writes (`qwr_en`) and `go` pulses that arrive while `busy` is 1 have no effect.
- R8: The two-bit chip-select field of a slot selects which `cs_n[k]` goes low (k = field value). At most one line is low at any time.
- R9: A half period lasts `half_div` cycles. A `half_div` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| qwr_en | input | 1 | Write one queue slot |
| qwr_idx | input | 4 | Slot index for the write |
| qwr_tx | input | 8 | Byte to transmit |
| qwr_cont | input | 1 | Continue flag: keep chip select low after this slot |
| qwr_cs | input | 2 | Chip-select choice for this slot |
| rd_idx | input | 4 | Slot index for receive readback |
| rd_rx | output | 8 | Received byte of slot `rd_idx` |
| first_ptr | input | 4 | First slot of the run |
| last_ptr | input | 4 | Last slot of the run (inclusive) |
| go | input | 1 | Start pulse |
| lock | input | 1 | Keep chip select low across runs |
| cont_after | input | 1 | Per-run request, with lock, to hold chip select at run end |
| done_clr | input | 1 | Clear the completion flag |
| half_div | input | 8 | Half period of `sck` in system cycles |
| busy | output | 1 | Run in progress (the enable bit) |
| done | output | 1 | Sticky completion flag |
| sck | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 4 | Active-low chip selects |

## Verification
The sharpest collisions are host actions that arrive during a run: a slot write or a second `go` in the middle of shifting, and the run's final edge, where the `lock` level decides whether chip select is released in the same cycle that `busy` drops. The bench rewrites a slot in mid-run, pulses `go` again and holds `lock` across two runs. A behavioural model decides on every clock what `sck`, `mosi`, `cs_n`, `busy` and `done` must be. The ignored write is then shown at the pins by running that slot again and capturing the byte it sends.

// File: rtl/spiq_pkg.sv
// Shared types of the queued SPI master.
// Assumes: one byte per slot, sequencer states encoded in two bits.
package spiq_pkg;
    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] spiq_byte_t;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_GAP   = 2'd2,
        SQ_FIN   = 2'd3
    } sq_state_e;
endpackage

// File: rtl/spiq_phase_timer.sv
// Half-period timer: ticks at the last cycle of each sck half period.
// Assumes: half_div is steady during a run; a value of 0 is treated as 1.
module spiq_phase_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Effective half-period length, never zero.
    assign lim  = (half_div == '0) ? DIV_W'(1) : half_div;
    assign tick = run && (cnt_q == lim - 1'b1);

    // Count cycles inside the current half period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spiq_slot_store.sv
// Queue storage: transmit byte, continue flag, chip-select field and
// received byte per slot. Host writes are dropped while a run is busy.
// Assumes: the engine is the only writer of received bytes.
module spiq_slot_store
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int AW    = 4,
    parameter int CSW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           busy,
    input  logic           host_we,
    input  logic [AW-1:0]  host_idx,
    input  spiq_byte_t     host_tx,
    input  logic           host_cont,
    input  logic [CSW-1:0] host_cs,
    input  logic [AW-1:0]  host_rd_idx,
    output spiq_byte_t     host_rx,
    input  logic [AW-1:0]  eng_idx,
    output spiq_byte_t     eng_tx,
    output logic           eng_cont,
    output logic [CSW-1:0] eng_cs,
    input  logic           rx_we,
    input  logic [AW-1:0]  rx_idx,
    input  spiq_byte_t     rx_data
);
    spiq_byte_t     tx_q   [DEPTH];
    spiq_byte_t     rx_q   [DEPTH];
    logic           cont_q [DEPTH];
    logic [CSW-1:0] cs_q   [DEPTH];

    // Slot register file with host and engine write ports.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < DEPTH; s++) begin
                tx_q[s]   <= '0;
                rx_q[s]   <= '0;
                cont_q[s] <= 1'b0;
                cs_q[s]   <= '0;
            end
        end else begin
            for (int s = 0; s < DEPTH; s++) begin
                if (host_we && !busy && host_idx == AW'(s)) begin
                    tx_q[s]   <= host_tx;
                    cont_q[s] <= host_cont;
                    cs_q[s]   <= host_cs;
                end
                if (rx_we && rx_idx == AW'(s)) begin
                    rx_q[s] <= rx_data;
                end
            end
        end
    end

    // Combinational read ports.
    assign eng_tx   = tx_q[eng_idx];
    assign eng_cont = cont_q[eng_idx];
    assign eng_cs   = cs_q[eng_idx];
    assign host_rx  = rx_q[host_rd_idx];
endmodule

// File: rtl/spiq_sequencer.sv
// Run sequencer: walks the slots, drives sck/mosi/cs_n in clock mode 3,
// samples miso on the rising half, handles gaps, end-of-run hold and the
// enable/done handshake.
// Assumes: slot data read combinationally at slot_idx in the same cycle.
module spiq_sequencer
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NCS   = 4,
    parameter int AW    = 4,
    parameter int CSW   = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           go,
    input  logic           lock,
    input  logic           cont_after,
    input  logic           done_clr,
    input  logic           tick,
    input  logic           miso,
    input  logic [AW-1:0]  first_ptr,
    input  logic [AW-1:0]  last_ptr,
    output logic [AW-1:0]  slot_idx,
    input  spiq_byte_t     slot_tx,
    input  logic           slot_cont,
    input  logic [CSW-1:0] slot_cs,
    output logic           rx_we,
    output logic [AW-1:0]  rx_idx,
    output spiq_byte_t     rx_data,
    output logic           run,
    output logic           hold,
    output logic           busy,
    output logic           done,
    output logic           sck,
    output logic           mosi,
    output logic [NCS-1:0] cs_n
);
    sq_state_e      state_q;
    logic [AW-1:0]  ptr_q, last_q, nxt_ptr;
    logic [2:0]     bit_q;
    spiq_byte_t     txsh_q;
    logic [6:0]     rxsh_q;
    logic           cur_cont_q, keep_q;
    logic           sck_q, mosi_q, busy_q, done_q, hold_q;
    logic [NCS-1:0] csn_q, csn_sel;

    // Decode the slot's chip-select field into active-low lines.
    for (genvar c = 0; c < NCS; c++) begin : g_csdec
        assign csn_sel[c] = (slot_cs != CSW'(c));
    end

    // Next slot index with wrap at the queue end.
    assign nxt_ptr = (ptr_q == AW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;

    // Storage address: start slot when idle, pending slot in a gap, else next.
    always_comb begin
        case (state_q)
            SQ_IDLE: slot_idx = first_ptr;
            SQ_GAP:  slot_idx = ptr_q;
            default: slot_idx = nxt_ptr;
        endcase
    end

    // Store the received byte on the eighth rising-half sample.
    assign rx_we   = (state_q == SQ_SHIFT) && tick && !sck_q && (bit_q == 3'd0);
    assign rx_idx  = ptr_q;
    assign rx_data = {rxsh_q, miso};
    assign run     = (state_q == SQ_SHIFT) || (state_q == SQ_GAP);

    // Main sequencing register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= SQ_IDLE;
            ptr_q      <= '0;
            last_q     <= '0;
            bit_q      <= 3'd7;
            txsh_q     <= '0;
            rxsh_q     <= '0;
            cur_cont_q <= 1'b0;
            keep_q     <= 1'b0;
            sck_q      <= 1'b1;
            mosi_q     <= 1'b1;
            busy_q     <= 1'b0;
            done_q     <= 1'b0;
            hold_q     <= 1'b0;
            csn_q      <= '1;
        end else begin
            if (done_clr) begin
                done_q <= 1'b0;
            end
            case (state_q)
                SQ_IDLE: begin
                    if (go) begin
                        state_q    <= SQ_SHIFT;
                        busy_q     <= 1'b1;
                        hold_q     <= 1'b0;
                        keep_q     <= cont_after;
                        last_q     <= last_ptr;
                        ptr_q      <= first_ptr;
                        bit_q      <= 3'd7;
                        txsh_q     <= slot_tx;
                        mosi_q     <= slot_tx[7];
                        sck_q      <= 1'b0;
                        csn_q      <= csn_sel;
                        cur_cont_q <= slot_cont;
                    end else if (hold_q && !lock) begin
                        hold_q <= 1'b0;
                        csn_q  <= '1;
                    end
                end
                SQ_SHIFT: begin
                    if (tick) begin
                        if (!sck_q) begin
                            sck_q  <= 1'b1;
                            rxsh_q <= {rxsh_q[5:0], miso};
                        end else if (bit_q != 3'd0) begin
                            sck_q  <= 1'b0;
                            bit_q  <= bit_q - 1'b1;
                            txsh_q <= {txsh_q[6:0], 1'b0};
                            mosi_q <= txsh_q[6];
                        end else if (ptr_q == last_q) begin
                            state_q <= SQ_FIN;
                            busy_q  <= 1'b0;
                            if (lock && keep_q) begin
                                hold_q <= 1'b1;
                            end else begin
                                csn_q <= '1;
                            end
                        end else if (cur_cont_q) begin
                            ptr_q      <= nxt_ptr;
                            bit_q      <= 3'd7;
                            txsh_q     <= slot_tx;
                            mosi_q     <= slot_tx[7];
                            sck_q      <= 1'b0;
                            csn_q      <= csn_sel;
                            cur_cont_q <= slot_cont;
                        end else begin
                            ptr_q   <= nxt_ptr;
                            state_q <= SQ_GAP;
                            csn_q   <= '1;
                        end
                    end
                end
                SQ_GAP: begin
                    if (tick) begin
                        state_q    <= SQ_SHIFT;
                        bit_q      <= 3'd7;
                        txsh_q     <= slot_tx;
                        mosi_q     <= slot_tx[7];
                        sck_q      <= 1'b0;
                        csn_q      <= csn_sel;
                        cur_cont_q <= slot_cont;
                    end
                end
                default: begin
                    done_q  <= 1'b1;
                    state_q <= SQ_IDLE;
                end
            endcase
        end
    end

    assign hold = hold_q;
    assign busy = busy_q;
    assign done = done_q;
    assign sck  = sck_q;
    assign mosi = mosi_q;
    assign cs_n = csn_q;
endmodule

// File: rtl/spiq_engine.sv
// Top of the queued SPI master: slot storage, half-period timer and sequencer.
// Assumes: host inputs are synchronous to clk; miso is synchronous or slow.
module spiq_engine
    import spiq_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int NCS   = 4,
    parameter int DIV_W = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CSW  = $clog2(NCS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             qwr_en,
    input  logic [AW-1:0]    qwr_idx,
    input  logic [7:0]       qwr_tx,
    input  logic             qwr_cont,
    input  logic [CSW-1:0]   qwr_cs,
    input  logic [AW-1:0]    rd_idx,
    output logic [7:0]       rd_rx,
    input  logic [AW-1:0]    first_ptr,
    input  logic [AW-1:0]    last_ptr,
    input  logic             go,
    input  logic             lock,
    input  logic             cont_after,
    input  logic             done_clr,
    input  logic [DIV_W-1:0] half_div,
    output logic             busy,
    output logic             done,
    output logic             sck,
    output logic             mosi,
    input  logic             miso,
    output logic [NCS-1:0]   cs_n
);
    logic           tick_w, run_w, hold_w, rx_we_w, eng_cont_w;
    logic [AW-1:0]  eng_idx_w, rx_idx_w;
    spiq_byte_t     eng_tx_w, rx_data_w;
    logic [CSW-1:0] eng_cs_w;

    spiq_phase_timer #(.DIV_W(DIV_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .half_div (half_div),
        .tick     (tick_w)
    );

    spiq_slot_store #(.DEPTH(DEPTH), .AW(AW), .CSW(CSW)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .busy        (busy),
        .host_we     (qwr_en),
        .host_idx    (qwr_idx),
        .host_tx     (qwr_tx),
        .host_cont   (qwr_cont),
        .host_cs     (qwr_cs),
        .host_rd_idx (rd_idx),
        .host_rx     (rd_rx),
        .eng_idx     (eng_idx_w),
        .eng_tx      (eng_tx_w),
        .eng_cont    (eng_cont_w),
        .eng_cs      (eng_cs_w),
        .rx_we       (rx_we_w),
        .rx_idx      (rx_idx_w),
        .rx_data     (rx_data_w)
    );

    spiq_sequencer #(.DEPTH(DEPTH), .NCS(NCS), .AW(AW), .CSW(CSW)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .lock       (lock),
        .cont_after (cont_after),
        .done_clr   (done_clr),
        .tick       (tick_w),
        .miso       (miso),
        .first_ptr  (first_ptr),
        .last_ptr   (last_ptr),
        .slot_idx   (eng_idx_w),
        .slot_tx    (eng_tx_w),
        .slot_cont  (eng_cont_w),
        .slot_cs    (eng_cs_w),
        .rx_we      (rx_we_w),
        .rx_idx     (rx_idx_w),
        .rx_data    (rx_data_w),
        .run        (run_w),
        .hold       (hold_w),
        .busy       (busy),
        .done       (done),
        .sck        (sck),
        .mosi       (mosi),
        .cs_n       (cs_n)
    );
endmodule

// File: rtl/spiq_engine_chk.sv
// Property checker for spiq_engine, attached by bind below.
// Assumes: connected to the engine's ports and its internal hold state.
module spiq_engine_chk #(
    parameter int NCS = 4
) (
    input logic           clk,
    input logic           rst_n,
    input logic           busy,
    input logic           done,
    input logic           sck,
    input logic           mosi,
    input logic           hold,
    input logic [NCS-1:0] cs_n
);
    // At most one chip select is active.
    assert_cs_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // The completion flag follows the end of the enable bit.
    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |=> done);

    // The completion flag only rises when the enable bit was already low.
    assert_done_rise_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (!busy && !$past(busy)));

    // The serial clock idles high outside a run.
    assert_sck_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck);

    // With no hold pending, an idle engine drives no chip select.
    assert_cs_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !hold) |-> (&cs_n));

    // Data holds steady while sck stays high during a run.
    assert_mosi_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sck && $past(sck)) |-> $stable(mosi));
endmodule

bind spiq_engine spiq_engine_chk #(.NCS(NCS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .sck   (sck),
    .mosi  (mosi),
    .hold  (hold_w),
    .cs_n  (cs_n)
);

// File: tb/tb_spiq_engine.sv
// Bench for spiq_engine: a behavioural per-cycle model compared on every clock.
module tb_spiq_engine;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       qwr_en = 1'b0;
    logic [3:0] qwr_idx = '0;
    logic [7:0] qwr_tx = '0;
    logic       qwr_cont = 1'b0;
    logic [1:0] qwr_cs = '0;
    logic [3:0] rd_idx = '0;
    logic [7:0] rd_rx;
    logic [3:0] first_ptr = '0;
    logic [3:0] last_ptr = '0;
    logic       go = 1'b0;
    logic       lock = 1'b0;
    logic       cont_after = 1'b0;
    logic       done_clr = 1'b0;
    logic [7:0] half_div = 8'd2;
    logic       busy, done, sck, mosi;
    logic       miso = 1'b0;
    logic [3:0] cs_n;

    always #2 clk = ~clk;

    spiq_engine dut (
        .clk(clk), .rst_n(rst_n), .qwr_en(qwr_en), .qwr_idx(qwr_idx),
        .qwr_tx(qwr_tx), .qwr_cont(qwr_cont), .qwr_cs(qwr_cs),
        .rd_idx(rd_idx), .rd_rx(rd_rx), .first_ptr(first_ptr),
        .last_ptr(last_ptr), .go(go), .lock(lock), .cont_after(cont_after),
        .done_clr(done_clr), .half_div(half_div), .busy(busy), .done(done),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n)
    );

    int    checks = 0;
    int    errors = 0;
    bit    finished = 0;
    bit    started = 0;
    string scen = "R1";

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s [%s]: actual %0h expected %0h", tag, what, scen, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    // Slave byte pattern, indexed by byte number within a run.
    function automatic logic [7:0] sb(input int k);
        return 8'h3C ^ 8'((k * 29) & 255);
    endfunction

    function automatic logic [3:0] sel2n(input logic [1:0] s);
        return ~(4'b0001 << s);
    endfunction

    // Mode-3 slave: presents the next bit on each falling sck.
    int scnt = 0;
    always @(negedge sck) begin
        logic [7:0] t;
        if (cs_n != 4'hF) begin
            t = sb(scnt / 8);
            miso <= t[7 - (scnt % 8)];
            scnt = scnt + 1;
        end
    end

    // Bytes seen by a receiver on rising sck.
    logic [7:0] mosi_cap = '0;
    always @(posedge sck) if (cs_n != 4'hF) mosi_cap <= {mosi_cap[6:0], mosi};

    // ---------------- reference model ----------------
    typedef struct packed {
        bit       sck;
        bit       mosi;
        bit       mc;
        bit [3:0] csn;
        bit       busy;
        bit       done;
    } ent_t;

    ent_t       q[$];
    logic [7:0] m_tx  [DEPTH];
    bit         m_cont[DEPTH];
    logic [1:0] m_cs  [DEPTH];
    logic [7:0] m_rx  [DEPTH];
    bit         e_sck = 1, e_mosi = 1, e_mc = 0, e_busy = 0, e_done = 0;
    bit [3:0]   e_csn = 4'hF;
    bit         m_hold = 0, m_done = 0;
    bit [3:0]   m_hold_csn = 4'hF;

    task automatic push_n(input int n, input ent_t e);
        for (int i = 0; i < n; i++) q.push_back(e);
    endtask

    task automatic build();
        int   d;
        int   p;
        int   j;
        bit   hl;
        ent_t e;
        d  = (half_div == 0) ? 1 : int'(half_div);
        p  = int'(first_ptr);
        j  = 0;
        hl = lock && cont_after;
        forever begin
            for (int b = 7; b >= 0; b--) begin
                e = '{sck:0, mosi:m_tx[p][b], mc:1, csn:sel2n(m_cs[p]), busy:1, done:m_done};
                push_n(d, e);
                e.sck = 1;
                push_n(d, e);
            end
            m_rx[p] = sb(j);
            j++;
            if (p == int'(last_ptr)) break;
            if (!m_cont[p]) begin
                e = '{sck:1, mosi:0, mc:0, csn:4'hF, busy:1, done:m_done};
                push_n(d, e);
            end
            p = (p + 1) % DEPTH;
        end
        m_hold     = hl;
        m_hold_csn = sel2n(m_cs[p]);
        e = '{sck:1, mosi:0, mc:0, csn:(hl ? m_hold_csn : 4'hF), busy:0, done:m_done};
        q.push_back(e);
        e.done = 1;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        ent_t e;
        bit   was_idle;
        bit   cur_busy;
        started = 1;
        if (!rst_n) begin
            q.delete();
            e_sck = 1; e_mosi = 1; e_mc = 0; e_csn = 4'hF; e_busy = 0; e_done = 0;
            m_hold = 0; m_done = 0;
            for (int s = 0; s < DEPTH; s++) begin
                m_tx[s] = '0; m_cont[s] = 0; m_cs[s] = '0; m_rx[s] = '0;
            end
        end else begin
            was_idle = (q.size() == 0);
            cur_busy = e_busy;
            if (done_clr) m_done = 0;
            if (was_idle && go) build();
            else if (was_idle && m_hold && !lock) m_hold = 0;
            if (qwr_en && !cur_busy) begin
                m_tx[qwr_idx] = qwr_tx; m_cont[qwr_idx] = qwr_cont; m_cs[qwr_idx] = qwr_cs;
            end
            if (q.size() > 0) begin
                e = q.pop_front();
                e_sck = e.sck; e_mosi = e.mosi; e_mc = e.mc; e_csn = e.csn;
                e_busy = e.busy; e_done = e.done; m_done = e.done;
            end else begin
                e_sck = 1; e_mc = 0; e_busy = 0; e_done = m_done;
                e_csn = m_hold ? m_hold_csn : 4'hF;
            end
        end
    end

    // Per-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (started && !finished) begin
            chk(sck === e_sck, "R2", "sck", int'(sck), int'(e_sck));
            chk(cs_n === e_csn, "R4", "cs_n", int'(cs_n), int'(e_csn));
            chk(busy === e_busy, "R5", "busy", int'(busy), int'(e_busy));
            chk(done === e_done, "R5", "done", int'(done), int'(e_done));
            if (e_mc) chk(mosi === e_mosi, "R2", "mosi", int'(mosi), int'(e_mosi));
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr_slot(input int idx, input logic [7:0] tx, input bit cont, input int cs);
        @(negedge clk);
        qwr_en = 1; qwr_idx = 4'(idx); qwr_tx = tx; qwr_cont = cont; qwr_cs = 2'(cs);
        @(negedge clk);
        qwr_en = 0;
    endtask

    task automatic start_run(input int f, input int l);
        @(negedge clk);
        scnt = 0; mosi_cap = '0;
        first_ptr = 4'(f); last_ptr = 4'(l); go = 1;
        @(negedge clk);
        go = 0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk); done_clr = 1;
        @(negedge clk); done_clr = 0;
    endtask

    task automatic check_rx(input int idx);
        rd_idx = 4'(idx);
        #1;
        chk(rd_rx === m_rx[idx], "R3", $sformatf("rx slot %0d", idx), int'(rd_rx), int'(m_rx[idx]));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the pins
        chk(busy === 0 && done === 0, "R1", "busy/done", int'({busy, done}), 0);
        chk(sck === 1 && cs_n === 4'hF, "R1", "sck/cs_n", int'({sck, cs_n}), 'h1F);
        rst_n = 1;
        repeat (2) @(negedge clk);

        // Run A: gaps, straight continues, chip-select choices
        scen = "R2 R4 R8";
        half_div = 8'd2;
        wr_slot(0, 8'hA5, 1, 0);
        wr_slot(1, 8'h3C, 1, 0);
        wr_slot(2, 8'h96, 0, 1);
        wr_slot(3, 8'hE1, 0, 3);
        start_run(0, 3);
        wait_idle();
        for (int i = 0; i < 4; i++) check_rx(i);
        chk(done === 1 && busy === 0, "R5", "done after run", int'({done, busy}), 2);
        pulse_clr();
        @(negedge clk);
        chk(done === 0, "R5", "done cleared", int'(done), 0);

        // Run B: wrap across the queue end, divider value 0 acts as 1
        scen = "R9 R2 wrap";
        half_div = 8'd0;
        wr_slot(14, 8'h5A, 1, 2);
        wr_slot(15, 8'hC3, 1, 2);
        start_run(14, 1);
        wait_idle();
        check_rx(14); check_rx(15); check_rx(0); check_rx(1);
        pulse_clr();

        // Run C: single slot, long half period
        scen = "R9";
        half_div = 8'd3;
        start_run(2, 2);
        wait_idle();
        check_rx(2);
        chk(mosi_cap === 8'h96, "R2", "byte sent MSB first", int'(mosi_cap), 'h96);
        pulse_clr();

        // Run D: held chip select across runs, writes and go while busy
        scen = "R6 R7";
        half_div = 8'd2;
        lock = 1; cont_after = 1;
        wr_slot(4, 8'h11, 1, 1);
        wr_slot(5, 8'h22, 1, 1);
        start_run(4, 5);
        repeat (10) @(negedge clk);
        wr_slot(4, 8'hFF, 0, 3);
        @(negedge clk); first_ptr = 4'd9; last_ptr = 4'd9; go = 1;
        @(negedge clk); go = 0;
        wait_idle();
        chk(cs_n === 4'b1101, "R6", "cs held after run", int'(cs_n), 'hD);
        pulse_clr();
        start_run(4, 4);
        wait_idle();
        chk(mosi_cap === 8'h11, "R7", "slot unchanged by busy write", int'(mosi_cap), 'h11);
        chk(cs_n === 4'b1101, "R6", "cs still held", int'(cs_n), 'hD);
        lock = 0; cont_after = 0;
        repeat (2) @(negedge clk);
        chk(cs_n === 4'hF, "R6", "cs released", int'(cs_n), 'hF);
        pulse_clr();
        repeat (4) @(negedge clk);
        finish_up();
    end
endmodule